// File: doc/BRIEF.md
# Interlocked Five-Stage Pipeline Core

This block is a small in-order processor core that runs a six-operation instruction set: register add, add of an 8-bit constant, load, store, unconditional jump and branch-when-nonzero. A halt operation ends a program. Each instruction passes through five stages in a fixed order: fetch, decode, operand fetch, execute and output save. There is no forwarding path. A per-register count of in-flight writers holds an instruction in decode until every older producer of its sources has finished output save. A load also waits while an older store to the same word is still in flight.

A jump or branch that leaves decode discards the instruction fetched behind it. Fetch then stays frozen until that control instruction has completed output save, and only in that stage is the program counter redirected. The core reads instructions from a synchronous ROM: the address goes out in one cycle and the word comes back in the next. The data memory has a combinational read port and a write port that takes effect at the clock edge. `done` rises once a halt has been decoded and every older instruction has drained.

Top module: `ipipe_core`

## Requirements
- R1: An instruction word is 23 bits wide: opcode in [22:20], field A in [19:16], field B in [15:12], field C in [11:8] and constant K in [7:0]. The opcodes are 0 no-op, 1 add, 2 add-constant, 3 load, 4 store, 5 jump, 6 branch-when-nonzero and 7 halt. There are 16 general registers of 16 bits each, and all of them start at zero after reset.
- R2: While reset is high, `done` and `dmem_we` stay low and the fetch address is 0.
- R3: Add writes reg[B]+reg[C] into reg[A]. Add-constant writes reg[B]+K (K zero-extended) into reg[A]. Both wrap modulo 2^16.
- R4: Load copies data word K into reg[A]. Store writes reg[A] into data word K during its output-save cycle.
- R5: A consumer of a register leaves decode in the cycle after its youngest older producer completes output save. A dependent pair of instructions therefore takes exactly 3 cycles longer than an independent pair.
- R6: A load does not read memory before an older in-flight store to the same word has been written.
- R7: A jump discards the instruction fetched behind it and freezes fetch until its own output save. Fetch then resumes at address K.
- R8: A branch-when-nonzero resumes fetch at K when reg[A] is nonzero, and otherwise at the word that follows the branch. The word fetched behind the branch is never executed.
- R9: After a halt is decoded, no further instruction is fetched. `done` rises once the pipeline is empty and then stays high, and no data write occurs while it is high.
- R10: Any program leaves the same data memory contents as a one-at-a-time execution of that program in program order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction ROM address |
| imem_rdata | input | 23 | ROM word for the address sent in the previous cycle |
| dmem_raddr | output | 8 | Data read address (load in execute) |
| dmem_rdata | input | 16 | Combinational read data |
| dmem_we | output | 1 | Data write strobe (store in output save) |
| dmem_waddr | output | 8 | Data write address |
| dmem_wdata | output | 16 | Data write value |
| done | output | 1 | Program halted and pipeline empty |

## Verification
Two equivalent orderings of a twelve-line program, with a taken and an untaken branch, have to leave identical words at 10, 11 and 12, and the reordered one has to finish sooner. This shows that the interlocks cost cycles without changing the results. Directed programs separate the individual mechanisms. An independent pair is timed against a dependent pair, a store is followed by a load of the same word, and a store sits in the slot behind a jump and must be squashed. Seeded random straight-line mixes of arithmetic, loads and stores are then compared word by word against a sequential model, which exposes any missed register or memory hazard.

// File: rtl/ipipe_pkg.sv
package ipipe_pkg;
    localparam int DATA_W  = 16;
    localparam int REG_AW  = 4;
    localparam int NREG    = 1 << REG_AW;
    localparam int IMM_W   = 8;
    localparam int OP_W    = 3;
    localparam int INSTR_W = OP_W + 3 * REG_AW + IMM_W;
    localparam int BACK_STAGES = 3;                     // operand fetch, execute, save
    localparam int CNT_W   = $clog2(BACK_STAGES + 1);

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 3'd0,
        OP_ADD   = 3'd1,
        OP_ADDI  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4,
        OP_GOTO  = 3'd5,
        OP_BNZ   = 3'd6,
        OP_HALT  = 3'd7
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [REG_AW-1:0] ra;
        logic [REG_AW-1:0] rb;
        logic [REG_AW-1:0] rc;
        logic [IMM_W-1:0]  imm;
    } instr_t;

    typedef struct packed {
        op_e               op;
        logic [REG_AW-1:0] ra;
        logic [IMM_W-1:0]  imm;
    } tag_t;

    typedef struct packed {
        logic   v;
        instr_t ins;
    } opf_stage_t;

    typedef struct packed {
        logic              v;
        tag_t              t;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
    } exe_stage_t;

    typedef struct packed {
        logic              v;
        tag_t              t;
        logic [DATA_W-1:0] res;
    } sav_stage_t;

    function automatic logic writes_a(op_e op);
        return (op == OP_ADD) || (op == OP_ADDI) || (op == OP_LOAD);
    endfunction

    function automatic logic reads_a(op_e op);
        return (op == OP_STORE) || (op == OP_BNZ);
    endfunction

    function automatic logic reads_b(op_e op);
        return (op == OP_ADD) || (op == OP_ADDI);
    endfunction

    function automatic logic reads_c(op_e op);
        return op == OP_ADD;
    endfunction

    function automatic logic is_xfer(op_e op);
        return (op == OP_GOTO) || (op == OP_BNZ);
    endfunction

    function automatic logic store_hits(logic v, op_e op, logic [IMM_W-1:0] st_addr,
                                        logic [IMM_W-1:0] ld_addr);
        return v && (op == OP_STORE) && (st_addr == ld_addr);
    endfunction
endpackage

// File: rtl/ipipe_regfile.sv
module ipipe_regfile #(
    parameter int DW  = 16,
    parameter int AW  = 4,
    parameter int NRD = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);
    localparam int N = 1 << AW;

    logic [DW-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            assign rdata[g] = regs[raddr[g]];
        end
    endgenerate
endmodule

// File: rtl/ipipe_scoreboard.sv
module ipipe_scoreboard #(
    parameter int N  = 16,
    parameter int CW = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_en,
    input  logic [$clog2(N)-1:0] set_idx,
    input  logic                 clr_en,
    input  logic [$clog2(N)-1:0] clr_idx,
    output logic [N-1:0]         busy
);
    localparam int IW = $clog2(N);

    generate
        for (genvar g = 0; g < N; g++) begin : g_ent
            logic [CW-1:0] cnt;
            logic inc, dec;
            assign inc = set_en && (set_idx == IW'(g));
            assign dec = clr_en && (clr_idx == IW'(g));
            always_ff @(posedge clk) begin
                if (rst)              cnt <= '0;
                else if (inc && !dec) cnt <= cnt + 1'b1;
                else if (dec && !inc) cnt <= cnt - 1'b1;
            end
            assign busy[g] = |cnt;
        end
    endgenerate
endmodule

// File: rtl/ipipe_exec.sv
module ipipe_exec
    import ipipe_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic [DW-1:0] ld_val,
    input  logic [DW-1:0] st_val,
    output logic [DW-1:0] res
);
    always_comb begin
        case (op)
            OP_ADD, OP_ADDI: res = x + y;
            OP_LOAD:         res = ld_val;
            OP_STORE:        res = st_val;
            OP_BNZ:          res = {{(DW-1){1'b0}}, |x};
            default:         res = '0;
        endcase
    end
endmodule

// File: rtl/ipipe_core.sv
module ipipe_core
    import ipipe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [IMM_W-1:0]   imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [IMM_W-1:0]   dmem_raddr,
    input  logic [DATA_W-1:0]  dmem_rdata,
    output logic               dmem_we,
    output logic [IMM_W-1:0]   dmem_waddr,
    output logic [DATA_W-1:0]  dmem_wdata,
    output logic               done
);
    logic [IMM_W-1:0] pc, d_pc;
    logic             d_valid, ctl_pend, halted;
    instr_t           d_ins;
    opf_stage_t       o_q;
    exe_stage_t       e_q;
    sav_stage_t       s_q;
    logic [NREG-1:0]  busy;

    logic hazard, d_stall, d_go, d_ctl, d_halt, fetch_en;
    logic s_wr_en, s_redirect, s_xfer_done;
    logic [REG_AW-1:0] s_wr_idx;
    logic [REG_AW-1:0] rf_ra [3];
    logic [DATA_W-1:0] rf_rd [3];
    logic [DATA_W-1:0] e_res;

    assign d_ins = instr_t'(imem_rdata);

    // ---------------- decode interlock ----------------
    always_comb begin
        hazard = (reads_a(d_ins.op) && busy[d_ins.ra])
              || (reads_b(d_ins.op) && busy[d_ins.rb])
              || (reads_c(d_ins.op) && busy[d_ins.rc]);
        if (d_ins.op == OP_LOAD) begin
            hazard = hazard
                || store_hits(o_q.v, o_q.ins.op, o_q.ins.imm, d_ins.imm)
                || store_hits(e_q.v, e_q.t.op, e_q.t.imm, d_ins.imm)
                || store_hits(s_q.v, s_q.t.op, s_q.t.imm, d_ins.imm);
        end
    end

    assign d_stall  = d_valid && hazard;
    assign d_go     = d_valid && !hazard;
    assign d_ctl    = d_go && is_xfer(d_ins.op);
    assign d_halt   = d_go && (d_ins.op == OP_HALT);
    assign fetch_en = !d_stall && !ctl_pend && !d_ctl && !d_halt && !halted;

    // ---------------- fetch ----------------
    assign imem_addr = d_stall ? d_pc : pc;

    assign s_xfer_done = s_q.v && is_xfer(s_q.t.op);
    assign s_redirect  = s_q.v && ((s_q.t.op == OP_GOTO) ||
                                   ((s_q.t.op == OP_BNZ) && s_q.res[0]));

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            d_pc     <= '0;
            d_valid  <= 1'b0;
            ctl_pend <= 1'b0;
            halted   <= 1'b0;
        end else begin
            if (d_halt) halted <= 1'b1;
            if (d_ctl)            ctl_pend <= 1'b1;
            else if (s_xfer_done) ctl_pend <= 1'b0;
            if (s_redirect)    pc <= s_q.t.imm;
            else if (fetch_en) pc <= pc + 1'b1;
            if (!d_stall) begin
                d_valid <= fetch_en;
                d_pc    <= pc;
            end
        end
    end

    // ---------------- operand fetch ----------------
    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= '{v: d_go && (d_ins.op != OP_HALT), ins: d_ins};
    end

    always_comb begin
        rf_ra[0] = (o_q.ins.op == OP_BNZ) ? o_q.ins.ra : o_q.ins.rb;
        rf_ra[1] = o_q.ins.rc;
        rf_ra[2] = e_q.t.ra;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q <= '0;
        end else begin
            e_q.v <= o_q.v;
            e_q.t <= '{op: o_q.ins.op, ra: o_q.ins.ra, imm: o_q.ins.imm};
            e_q.x <= rf_rd[0];
            e_q.y <= (o_q.ins.op == OP_ADD) ? rf_rd[1] : DATA_W'(o_q.ins.imm);
        end
    end

    // ---------------- execute ----------------
    assign dmem_raddr = e_q.t.imm;

    ipipe_exec #(.DW(DATA_W)) u_exec (
        .op     (e_q.t.op),
        .x      (e_q.x),
        .y      (e_q.y),
        .ld_val (dmem_rdata),
        .st_val (rf_rd[2]),
        .res    (e_res)
    );

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= '{v: e_q.v, t: e_q.t, res: e_res};
    end

    // ---------------- output save ----------------
    assign s_wr_en    = s_q.v && writes_a(s_q.t.op);
    assign s_wr_idx   = s_q.t.ra;
    assign dmem_we    = s_q.v && (s_q.t.op == OP_STORE);
    assign dmem_waddr = s_q.t.imm;
    assign dmem_wdata = s_q.res;

    ipipe_regfile #(.DW(DATA_W), .AW(REG_AW), .NRD(3)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (s_wr_en),
        .waddr (s_wr_idx),
        .wdata (s_q.res),
        .raddr (rf_ra),
        .rdata (rf_rd)
    );

    ipipe_scoreboard #(.N(NREG), .CW(CNT_W)) u_sb (
        .clk     (clk),
        .rst     (rst),
        .set_en  (d_go && writes_a(d_ins.op)),
        .set_idx (d_ins.ra),
        .clr_en  (s_wr_en),
        .clr_idx (s_wr_idx),
        .busy    (busy)
    );

    assign done = halted && !o_q.v && !e_q.v && !s_q.v;
endmodule

// File: rtl/ipipe_checker.sv
module ipipe_checker
    import ipipe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              d_valid,
    input logic              d_ctl,
    input logic              ctl_pend,
    input logic              done,
    input logic              dmem_we,
    input logic              s_wr_en,
    input logic [REG_AW-1:0] s_wr_idx,
    input logic [NREG-1:0]   busy
);
    // R5: a register written in save must still be marked as having a writer in flight
    p_writer_tracked_r5: assert property (@(posedge clk) disable iff (rst)
        s_wr_en |-> busy[s_wr_idx]);

    // R7: the slot fetched behind a departing jump or branch is empty next cycle
    p_flush_slot_r7: assert property (@(posedge clk) disable iff (rst)
        d_ctl |=> !d_valid);

    // R7: while a control transfer is pending, decode receives nothing
    p_fetch_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        ctl_pend |-> !d_valid);

    // R9: done is sticky until reset
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R9: no data write once done
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !dmem_we);
endmodule

bind ipipe_core ipipe_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .d_valid  (d_valid),
    .d_ctl    (d_ctl),
    .ctl_pend (ctl_pend),
    .done     (done),
    .dmem_we  (dmem_we),
    .s_wr_en  (s_wr_en),
    .s_wr_idx (s_wr_idx),
    .busy     (busy)
);

// File: tb/ipipe_core_bench.sv
`timescale 1ns/1ps
module ipipe_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [22:0] imem_rdata;
    logic [7:0]  dmem_raddr;
    logic [15:0] dmem_rdata;
    logic        dmem_we;
    logic [7:0]  dmem_waddr;
    logic [15:0] dmem_wdata;
    logic        done;

    logic [22:0] rom [32];
    logic [15:0] mem [256];
    logic [15:0] exp_mem [256];

    int checks = 0;
    int errs   = 0;
    int total  = 0;

    localparam logic [2:0] NOP = 3'd0, ADD = 3'd1, ADDI = 3'd2, LD = 3'd3,
                           ST = 3'd4, JMP = 3'd5, BNZ = 3'd6, HLT = 3'd7;

    always #2.5 clk = ~clk;

    ipipe_core u_ipipe_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_raddr (dmem_raddr),
        .dmem_rdata (dmem_rdata),
        .dmem_we    (dmem_we),
        .dmem_waddr (dmem_waddr),
        .dmem_wdata (dmem_wdata),
        .done       (done)
    );

    always @(posedge clk) imem_rdata <= rom[imem_addr[4:0]];
    assign dmem_rdata = mem[dmem_raddr];
    always @(posedge clk) if (dmem_we) mem[dmem_waddr] <= dmem_wdata;

    always @(posedge clk) begin
        total++;
        if (total > 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog (all): actual=%0d expected<=%0d cycles", total, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    function automatic logic [22:0] enc(logic [2:0] op, int a, int b, int c, int k);
        return {op, a[3:0], b[3:0], c[3:0], k[7:0]};
    endfunction

    task automatic chk(logic ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 32; i++) rom[i] = enc(HLT, 0, 0, 0, 0);
    endtask

    task automatic run_prog(output int cyc);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) chk(1'b0, "R9 done timeout", cyc, 2000);
    endtask

    // sequential reference: one instruction at a time in program order
    task automatic model_run();
        logic [15:0] r [16];
        int p, nxt;
        logic [22:0] w;
        logic [2:0] op;
        int a, b, c, k;
        for (int i = 0; i < 16; i++) r[i] = '0;
        p = 0;
        for (int n = 0; n < 300; n++) begin
            w = rom[p[4:0]];
            op = w[22:20]; a = int'(w[19:16]); b = int'(w[15:12]);
            c = int'(w[11:8]); k = int'(w[7:0]);
            nxt = p + 1;
            if (op == HLT) break;
            case (op)
                ADD:  r[a] = r[b] + r[c];
                ADDI: r[a] = r[b] + 16'(k);
                LD:   r[a] = exp_mem[k];
                ST:   exp_mem[k] = r[a];
                JMP:  nxt = k;
                BNZ:  if (r[a] != 0) nxt = k;
                default: ;
            endcase
            p = nxt;
        end
    endtask

    task automatic load_example(bit reordered);
        clear_rom();
        if (!reordered) begin
            rom[0]  = enc(LD, 2, 0, 0, 2);
            rom[1]  = enc(LD, 1, 0, 0, 1);
        end else begin
            rom[0]  = enc(LD, 1, 0, 0, 1);
            rom[1]  = enc(LD, 2, 0, 0, 2);
        end
        rom[2]  = enc(BNZ, 1, 0, 0, 5);
        rom[3]  = enc(ADDI, 3, 1, 0, 20);
        rom[4]  = enc(JMP, 0, 0, 0, 6);
        rom[5]  = enc(ADDI, 3, 1, 0, 10);
        rom[6]  = enc(ADDI, 4, 2, 0, 5);
        if (!reordered) begin
            rom[7]  = enc(ST, 4, 0, 0, 10);
            rom[8]  = enc(ADDI, 5, 2, 0, 30);
            rom[9]  = enc(ST, 5, 0, 0, 11);
            rom[10] = enc(ADD, 8, 2, 3, 0);
        end else begin
            rom[7]  = enc(ADDI, 5, 2, 0, 30);
            rom[8]  = enc(ADD, 8, 2, 3, 0);
            rom[9]  = enc(ST, 4, 0, 0, 10);
            rom[10] = enc(ST, 5, 0, 0, 11);
        end
        rom[11] = enc(ST, 8, 0, 0, 12);
        rom[12] = enc(HLT, 0, 0, 0, 0);
    endtask

    initial begin
        int cyc_orig, cyc_re, cyc_ind, cyc_dep, cyc;

        for (int i = 0; i < 256; i++) mem[i] = '0;
        clear_rom();
        void'($urandom(32'd20240611));

        // R2: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R2 done in reset", int'(done), 0);
        chk(dmem_we == 1'b0, "R2 we in reset", int'(dmem_we), 0);
        chk(imem_addr == 8'd0, "R2 fetch addr", int'(imem_addr), 0);

        // R3 R4 R8 R10: example program, original order, untaken branch
        mem[1] = 16'd0; mem[2] = 16'd10;
        load_example(1'b0);
        run_prog(cyc_orig);
        chk(mem[10] == 16'd15, "R3 word10 orig", int'(mem[10]), 15);
        chk(mem[11] == 16'd40, "R4 word11 orig", int'(mem[11]), 40);
        chk(mem[12] == 16'd30, "R8 untaken word12 orig", int'(mem[12]), 30);

        // R10: reordered version gives the same results; R5: and retires sooner
        mem[10] = '0; mem[11] = '0; mem[12] = '0;
        load_example(1'b1);
        run_prog(cyc_re);
        chk(mem[10] == 16'd15, "R10 word10 reordered", int'(mem[10]), 15);
        chk(mem[11] == 16'd40, "R10 word11 reordered", int'(mem[11]), 40);
        chk(mem[12] == 16'd30, "R10 word12 reordered", int'(mem[12]), 30);
        chk(cyc_re < cyc_orig, "R5 reordered faster", cyc_re, cyc_orig - 1);

        // R8: taken branch (word1 = 3) -> R3 = 13, word12 = 23
        mem[1] = 16'd3; mem[10] = '0; mem[11] = '0; mem[12] = '0;
        load_example(1'b0);
        run_prog(cyc);
        chk(mem[12] == 16'd23, "R8 taken word12", int'(mem[12]), 23);
        chk(mem[10] == 16'd15, "R8 taken word10", int'(mem[10]), 15);

        // R7: store in the slot behind a jump must be squashed
        clear_rom();
        mem[20] = 16'hBEEF; mem[21] = '0;
        rom[0] = enc(JMP, 0, 0, 0, 2);
        rom[1] = enc(ST, 0, 0, 0, 20);
        rom[2] = enc(ADDI, 1, 0, 0, 9);
        rom[3] = enc(ST, 1, 0, 0, 21);
        run_prog(cyc);
        chk(mem[20] == 16'hBEEF, "R7 squashed slot", int'(mem[20]), 16'hBEEF);
        chk(mem[21] == 16'd9, "R7 target executed", int'(mem[21]), 9);

        // R6: load after store to the same word sees the new value
        clear_rom();
        mem[30] = 16'd99; mem[31] = '0;
        rom[0] = enc(ADDI, 1, 0, 0, 7);
        rom[1] = enc(ST, 1, 0, 0, 30);
        rom[2] = enc(LD, 2, 0, 0, 30);
        rom[3] = enc(ST, 2, 0, 0, 31);
        run_prog(cyc);
        chk(mem[31] == 16'd7, "R6 store then load", int'(mem[31]), 7);

        // R5: dependent pair costs exactly 3 more cycles than independent pair
        clear_rom();
        mem[40] = '0;
        rom[0] = enc(ADDI, 1, 0, 0, 5);
        rom[1] = enc(ADDI, 2, 0, 0, 6);
        rom[2] = enc(ST, 2, 0, 0, 40);
        run_prog(cyc_ind);
        chk(mem[40] == 16'd6, "R5 independent value", int'(mem[40]), 6);
        rom[1] = enc(ADDI, 2, 1, 0, 2);
        run_prog(cyc_dep);
        chk(mem[40] == 16'd7, "R5 dependent value", int'(mem[40]), 7);
        chk(cyc_dep - cyc_ind == 3, "R5 stall length", cyc_dep - cyc_ind, 3);

        // R9: done stays high and nothing is written afterwards
        mem[40] = 16'd1234;
        repeat (10) @(negedge clk);
        chk(done == 1'b1, "R9 done sticky", int'(done), 1);
        chk(mem[40] == 16'd1234, "R9 no write after done", int'(mem[40]), 1234);

        // R10 R1 R3 R4: seeded random straight-line programs vs sequential model
        for (int it = 0; it < 20; it++) begin
            clear_rom();
            for (int k = 0; k < 16; k++) begin
                int sel;
                sel = int'($urandom % 4);
                case (sel)
                    0: rom[k] = enc(ADD, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), 0);
                    1: rom[k] = enc(ADDI, int'($urandom % 8), int'($urandom % 8), 0, int'($urandom % 256));
                    2: rom[k] = enc(LD, int'($urandom % 8), 0, 0, 100 + int'($urandom % 4));
                    default: rom[k] = enc(ST, int'($urandom % 8), 0, 0, 100 + int'($urandom % 4));
                endcase
            end
            for (int j = 0; j < 8; j++) rom[16 + j] = enc(ST, j, 0, 0, 64 + j);
            for (int q = 0; q < 4; q++) mem[100 + q] = 16'($urandom);
            for (int j = 0; j < 8; j++) mem[64 + j] = '0;
            for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
            model_run();
            run_prog(cyc);
            for (int j = 0; j < 8; j++)
                chk(mem[64 + j] == exp_mem[64 + j], "R10 random register dump",
                    int'(mem[64 + j]), int'(exp_mem[64 + j]));
            for (int q = 0; q < 4; q++)
                chk(mem[100 + q] == exp_mem[100 + q], "R10 random memory word",
                    int'(mem[100 + q]), int'(exp_mem[100 + q]));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule